// File: doc/BRIEF.md
# Low-Power Infrared Pulse Timer

This block makes the short infrared marks used by a serial infrared link when it runs in its low-power pulse mode, and it screens incoming infrared pulses on the receive side. Software loads an 8-bit divisor through a simple write port and can read the value back. The block divides the system clock by that divisor to make a stream of one-cycle ticks, with one tick every divisor cycles. The ticks are brought out on their own pin. A divisor of zero is not a legal setting, and while it is loaded the tick stream stops.

A one-cycle transmit strobe asks for one infrared mark. The mark begins on the first tick after the strobe and lasts exactly three tick periods. On the receive side, the raw infrared input is synchronised to the system clock and then qualified. A pulse becomes valid only after it has stayed active for one full tick period, which is divisor system-clock cycles, so shorter glitches are dropped. The divisor should be chosen so that the tick rate lies strictly between 1.42 MHz and 2.12 MHz, with about 1.8432 MHz as the nominal rate. The marks are then roughly 1.41 to 2.11 µs wide.

There are three state machines. The tick generator has two states. It moves from TK_HALT to TK_RUN when the divisor becomes nonzero, and back to TK_HALT when the divisor becomes zero. The transmit shaper has three states. It moves from TX_IDLE to TX_ARMED on a strobe while the divisor is nonzero, and from TX_ARMED to TX_PULSE on a tick. It returns from TX_PULSE to TX_IDLE on the third tick of the mark. From either TX_ARMED or TX_PULSE it returns to TX_IDLE at once if the divisor becomes zero. The receive qualifier has three states. It moves from RX_IDLE to RX_QUAL when the synchronised input goes active, or straight to RX_VALID when the divisor is 1. It moves from RX_QUAL to RX_VALID once the input has been active for divisor cycles. From RX_QUAL or RX_VALID it returns to RX_IDLE when the input drops, and from RX_QUAL it also returns to RX_IDLE if the divisor is zero.

Top module: `lpir_pulse_timer`

## Requirements
- R1: After reset the divisor reads 0, and tick_o, ir_tx_o and rx_valid_o are all low.
- R2: A cycle with div_we high loads div_wdata into the divisor, and div_rdata shows the new value from the next cycle on.
- R3: With a nonzero divisor D, tick_o is high for single cycles spaced exactly D cycles apart. With D = 1 it is high every cycle.
- R4: While the divisor is 0, tick_o stays low.
- R5: A new nonzero divisor written while ticks are running takes effect at the next reload. Every tick period after the first tick that follows the write is D_new cycles.
- R6: After tx_mark_i, ir_tx_o goes high in the cycle right after the first tick that follows the strobe.
- R7: Each mark on ir_tx_o is high for exactly 3·D consecutive cycles.
- R8: A strobe while the divisor is 0 produces no mark. Writing 0 during a mark ends it within a few cycles. In both cases a later strobe with a nonzero divisor still produces a full mark.
- R9: A strobe that arrives while a mark is pending or in progress is ignored, and no second mark follows.
- R10: With divisor D ≥ 1, a raw high pulse of L cycles on ir_rx_i holds rx_valid_o high for max(0, L−D+1) cycles. rx_valid_o rises D+2 cycles after the input rises. A pulse shorter than D cycles is therefore rejected.
- R11: While the divisor is 0, rx_valid_o never goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| div_we | input | 1 | Divisor write enable |
| div_wdata | input | 8 | Divisor write value |
| div_rdata | output | 8 | Current divisor value |
| tx_mark_i | input | 1 | One-cycle request for one infrared mark |
| ir_rx_i | input | 1 | Raw infrared input, active high, asynchronous |
| ir_tx_o | output | 1 | Infrared mark output, active high |
| rx_valid_o | output | 1 | High while a qualified receive pulse is present |
| tick_o | output | 1 | Low-power tick, one cycle wide |

## Verification
Two situations are hard to reach from the ports. The first is a mark cut short because the divisor goes to zero in the middle of it. The bench reaches it by watching ir_tx_o rise and then writing zero a few cycles later, while the shaper is in TX_PULSE. It then confirms that the output falls and that a later strobe still gives a full mark. The second is the receive boundary, where pulses of D−1, D and D+3 cycles are driven. The bench counts the cycles during which rx_valid_o is high, and this exposes an off-by-one in the qualification count.

// File: rtl/lpir_pkg.sv
package lpir_pkg;
    typedef enum logic [0:0] {TK_HALT, TK_RUN} tick_state_t;
    typedef enum logic [1:0] {TX_IDLE, TX_ARMED, TX_PULSE} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_QUAL, RX_VALID} rx_state_t;
endpackage

// File: rtl/lpir_tick_gen.sv
module lpir_tick_gen
    import lpir_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    output logic [DIV_W-1:0] div_q,
    output logic             div_zero,
    output logic             tick_o
);
    tick_state_t      state, state_nx;
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else if (div_we) div_q <= div_wdata;
    end

    assign div_zero = (div_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TK_HALT;
        else state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TK_HALT: if (!div_zero) state_nx = TK_RUN;
            TK_RUN:  if (div_zero)  state_nx = TK_HALT;
            default: state_nx = TK_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else if (state == TK_RUN && !div_zero) begin
            if (cnt == '0) begin
                tick_o <= 1'b1;
                cnt    <= div_q - 1'b1;
            end else begin
                tick_o <= 1'b0;
                cnt    <= cnt - 1'b1;
            end
        end else begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end
    end

    assert_no_tick_when_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(div_q) == '0) |-> !tick_o);

    assert_tick_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && $past(div_q) > 1) |=> !tick_o);
endmodule

// File: rtl/lpir_tx_shaper.sv
module lpir_tx_shaper
    import lpir_pkg::*;
#(
    parameter int TX_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_zero,
    input  logic tick_i,
    input  logic tx_mark_i,
    output logic ir_tx_o
);
    localparam int PC_W = (TX_TICKS > 1) ? $clog2(TX_TICKS) : 1;
    localparam logic [PC_W-1:0] LAST_TICK = PC_W'(TX_TICKS - 1);

    tx_state_t       state, state_nx;
    logic [PC_W-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:  if (tx_mark_i && !div_zero) state_nx = TX_ARMED;
            TX_ARMED: begin
                if (div_zero)    state_nx = TX_IDLE;
                else if (tick_i) state_nx = TX_PULSE;
            end
            TX_PULSE: begin
                if (div_zero)                         state_nx = TX_IDLE;
                else if (tick_i && pcnt == LAST_TICK) state_nx = TX_IDLE;
            end
            default: state_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt <= '0;
        else if (state != TX_PULSE) pcnt <= '0;
        else if (tick_i) pcnt <= pcnt + 1'b1;
    end

    always_comb begin
        ir_tx_o = (state == TX_PULSE);
    end

    assert_mark_starts_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ir_tx_o) |-> $past(tick_i));

    assert_mark_tick_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_PULSE) |-> (pcnt <= LAST_TICK));

    assert_zero_div_drops_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE && div_zero) |=> (state == TX_IDLE));

    assert_strobe_ignored_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_PULSE && !tick_i && !div_zero) |=> (state == TX_PULSE));
endmodule

// File: rtl/lpir_rx_qual.sv
module lpir_rx_qual
    import lpir_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_q,
    input  logic             div_zero,
    input  logic             ir_rx_i,
    output logic             rx_valid_o
);
    rx_state_t        state, state_nx;
    logic [DIV_W-1:0] qcnt;
    logic [SYNC_STAGES-1:0] sync_ff;
    logic             rx_s;
    logic             qual_done;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_ff[0] <= 1'b0;
                    else sync_ff[0] <= ir_rx_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_ff[g] <= 1'b0;
                    else sync_ff[g] <= sync_ff[g-1];
                end
            end
        end
    endgenerate

    assign rx_s      = sync_ff[SYNC_STAGES-1];
    assign qual_done = (({1'b0, qcnt} + 1'b1) >= {1'b0, div_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE: begin
                if (rx_s && !div_zero)
                    state_nx = (div_q == DIV_W'(1)) ? RX_VALID : RX_QUAL;
            end
            RX_QUAL: begin
                if (!rx_s || div_zero) state_nx = RX_IDLE;
                else if (qual_done)    state_nx = RX_VALID;
            end
            RX_VALID: if (!rx_s) state_nx = RX_IDLE;
            default: state_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) qcnt <= '0;
        else if (state == RX_IDLE) qcnt <= DIV_W'(1);
        else if (state == RX_QUAL && rx_s) qcnt <= qcnt + 1'b1;
    end

    always_comb begin
        rx_valid_o = (state == RX_VALID);
    end

    assert_valid_needs_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid_o) |-> $past(rx_s));

    assert_no_qual_when_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && div_zero) |=> (state == RX_IDLE));
endmodule

// File: rtl/lpir_pulse_timer.sv
module lpir_pulse_timer
    import lpir_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int TX_TICKS    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    output logic [DIV_W-1:0] div_rdata,
    input  logic             tx_mark_i,
    input  logic             ir_rx_i,
    output logic             ir_tx_o,
    output logic             rx_valid_o,
    output logic             tick_o
);
    logic [DIV_W-1:0] div_q;
    logic             div_zero;

    lpir_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_we    (div_we),
        .div_wdata (div_wdata),
        .div_q     (div_q),
        .div_zero  (div_zero),
        .tick_o    (tick_o)
    );

    lpir_tx_shaper #(.TX_TICKS(TX_TICKS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_zero  (div_zero),
        .tick_i    (tick_o),
        .tx_mark_i (tx_mark_i),
        .ir_tx_o   (ir_tx_o)
    );

    lpir_rx_qual #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_q      (div_q),
        .div_zero   (div_zero),
        .ir_rx_i    (ir_rx_i),
        .rx_valid_o (rx_valid_o)
    );

    assign div_rdata = div_q;
endmodule

// File: tb/lpir_pulse_timer_bench.sv
module lpir_pulse_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_we = 1'b0;
    logic [7:0] div_wdata = '0;
    logic [7:0] div_rdata;
    logic       tx_mark_i = 1'b0;
    logic       ir_rx_i = 1'b0;
    logic       ir_tx_o, rx_valid_o, tick_o;
    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    lpir_pulse_timer u_lpir_pulse_timer (
        .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_wdata(div_wdata),
        .div_rdata(div_rdata), .tx_mark_i(tx_mark_i), .ir_rx_i(ir_rx_i),
        .ir_tx_o(ir_tx_o), .rx_valid_o(rx_valid_o), .tick_o(tick_o)
    );

    always @(negedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_div(input int d);
        @(negedge clk);
        div_we = 1'b1; div_wdata = 8'(d);
        @(negedge clk);
        div_we = 1'b0;
    endtask

    task automatic wait_tick(output bit seen);
        seen = 0;
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            if (tick_o) begin seen = 1; break; end
        end
    endtask

    task automatic period(output int p);
        p = 0;
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            p++;
            if (tick_o) break;
        end
    endtask

    task automatic test_reset();
        chk(div_rdata == 0, "R1 div", div_rdata, 0);
        chk(!tick_o && !ir_tx_o && !rx_valid_o, "R1 outs",
            int'({tick_o, ir_tx_o, rx_valid_o}), 0);
    endtask

    task automatic test_ticks(input int d);
        bit s; int p;
        write_div(d);
        chk(div_rdata == 8'(d), "R2 readback", div_rdata, d);
        wait_tick(s);
        chk(s, "R3 first tick", s, 1);
        for (int k = 0; k < 3; k++) begin
            period(p);
            chk(p == d, "R3 period", p, d);
        end
    endtask

    task automatic test_zero_ticks();
        int n = 0;
        write_div(0);
        @(negedge clk);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (tick_o) n++;
        end
        chk(n == 0, "R4 ticks with zero divisor", n, 0);
    endtask

    task automatic test_reload(input int d0, input int d1);
        bit s; int p;
        write_div(d0);
        wait_tick(s);
        repeat (2) @(negedge clk);
        write_div(d1);
        wait_tick(s);
        for (int k = 0; k < 2; k++) begin
            period(p);
            chk(p == d1, "R5 period after reload", p, d1);
        end
    endtask

    task automatic tx_measure(input int d, input string tag);
        bit prev_tick = 0; bit started = 0; int w = 0;
        @(negedge clk);
        tx_mark_i = 1'b1;
        @(negedge clk);
        tx_mark_i = 1'b0;
        prev_tick = tick_o;
        for (int i = 0; i < 4 * d + 10 && !started; i++) begin
            if (ir_tx_o) started = 1;
            else begin
                prev_tick = tick_o;
                @(negedge clk);
            end
        end
        chk(started && prev_tick, {tag, " R6 start after tick"}, int'(prev_tick), 1);
        while (ir_tx_o && w < 4 * d + 10) begin
            w++;
            @(negedge clk);
        end
        chk(w == 3 * d, {tag, " R7 width"}, w, 3 * d);
    endtask

    task automatic test_tx(input int d);
        write_div(d);
        repeat (3) @(negedge clk);
        tx_measure(d, "tx");
    endtask

    task automatic test_tx_zero();
        int n = 0;
        write_div(0);
        @(negedge clk);
        tx_mark_i = 1'b1;
        @(negedge clk);
        tx_mark_i = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ir_tx_o) n++;
        end
        chk(n == 0, "R8 mark with zero divisor", n, 0);
        write_div(2);
        repeat (3) @(negedge clk);
        tx_measure(2, "R8 recover");
        for (int i = 0; i < 60 && !ir_tx_o; i++) begin
            if (i == 0) begin
                write_div(4);
                repeat (2) @(negedge clk);
                tx_mark_i = 1'b1;
                @(negedge clk);
                tx_mark_i = 1'b0;
            end else @(negedge clk);
        end
        repeat (3) @(negedge clk);
        write_div(0);
        repeat (3) @(negedge clk);
        chk(!ir_tx_o, "R8 abort on zero", ir_tx_o, 0);
        write_div(3);
        repeat (3) @(negedge clk);
        tx_measure(3, "R8 after abort");
    endtask

    task automatic test_tx_busy(input int d);
        int n = 0;
        write_div(d);
        repeat (3) @(negedge clk);
        tx_mark_i = 1'b1;
        @(negedge clk);
        tx_mark_i = 1'b0;
        @(negedge clk);
        tx_mark_i = 1'b1;
        @(negedge clk);
        tx_mark_i = 1'b0;
        for (int i = 0; i < 8 * d + 10; i++) begin
            @(negedge clk);
            if (ir_tx_o) n++;
        end
        chk(n == 3 * d, "R9 one mark only", n, 3 * d);
    endtask

    task automatic rx_pulse(input int d, input int len, input string tag);
        int n = 0; int rise = -1; int exp;
        ir_rx_i = 1'b1;
        for (int i = 0; i < len + 12; i++) begin
            @(negedge clk);
            if (i == len - 1) ir_rx_i = 1'b0;
            if (rx_valid_o) begin
                n++;
                if (rise < 0) rise = i + 1;
            end
        end
        ir_rx_i = 1'b0;
        exp = (len >= d) ? len - d + 1 : 0;
        chk(n == exp, {tag, " valid cycles"}, n, exp);
        if (exp > 0) chk(rise == d + 2, {tag, " R10 latency"}, rise, d + 2);
    endtask

    task automatic test_rx(input int d);
        write_div(d);
        repeat (3) @(negedge clk);
        if (d > 1) rx_pulse(d, d - 1, "R10 short");
        rx_pulse(d, d, "R10 exact");
        rx_pulse(d, d + 3, "R10 long");
    endtask

    task automatic test_rx_zero();
        write_div(0);
        repeat (3) @(negedge clk);
        rx_pulse(300, 30, "R11 zero divisor");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_zero_ticks();
        test_ticks(1);
        test_ticks(3);
        test_ticks(7);
        test_zero_ticks();
        test_reload(9, 4);
        test_reload(3, 6);
        test_tx(1);
        test_tx(2);
        test_tx(5);
        test_tx_zero();
        test_tx_busy(3);
        test_rx(1);
        test_rx(4);
        test_rx(9);
        test_rx_zero();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule